// File: doc/BRIEF.md
# USB Device Interrupt and Address Register Bank

This block holds the interrupt and addressing state of a small USB peripheral controller. A host processor reaches it over a synchronous 8-bit bus made of an address, write data, a write strobe and read data. Three registers are visible. The interrupt mask sits at offset 06h. The device address sits at offset 07h. The combined event status and write-1-to-clear register sits at offset 0Dh.

One-cycle event pulses from the endpoint logic, the start-of-frame detector, the bus-reset detector and the DMA engine are caught in sticky status bits. These bits latch whether or not their mask bit is set. A registered, active-high interrupt request is raised while any pending event has its mask bit set. The top status bit is not a latch: it follows the DMA engine's busy level directly and never raises an interrupt.

The block also compares each incoming 7-bit token address with the stored device address and reports a match.

Top module: `usbdev_irq_regs`

## Requirements
- R1: After reset, offsets 06h and 07h read 00h, status bits 6:0 read 0, and `irq` is 0.
- R2: A write to offset 06h stores all 8 bits in the mask register, and a read of 06h returns them.
- R3: A write to offset 07h stores all 8 bits in the device address register, and a read of 07h returns them.
- R4: Status bit layout at 0Dh: bit 6 is bus reset, bit 5 is start-of-frame, bit 4 is DMA done, and bits 3:0 are endpoints 3 to 0 done. A pulse on an event input sets its bit, whatever the mask holds. The bit then stays set until it is cleared.
- R5: A write to 0Dh clears each status bit whose write-data bit is 1 and leaves each bit written 0 unchanged.
- R6: If an event pulse and a clear hit the same status bit in the same cycle, the bit ends up set.
- R7: Reading 0Dh returns the live `dma_busy` level in bit 7. Neither this level nor mask bit 7 ever affects `irq`.
- R8: `irq` is a register. One cycle after any cycle in which some status bit 6:0 and the mask bit at the same position are both 1, `irq` is 1. Otherwise it is 0 in that cycle.
- R9: `addr_hit` is 1 exactly when `tok_addr` equals bits 6:0 of the device address register. Bit 7 of that register is ignored.
- R10: Writes to any offset other than 06h, 07h and 0Dh change no register. Reads of such offsets return 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ev_ep_done | input | 4 | Endpoint-done pulses, bit n for endpoint n |
| ev_dma_done | input | 1 | DMA-done pulse |
| ev_sof | input | 1 | Start-of-frame pulse |
| ev_bus_reset | input | 1 | Bus-reset-detected pulse |
| dma_busy | input | 1 | Level, high while a DMA transfer runs |
| tok_addr | input | 7 | Address field of the current token |
| addr_hit | output | 1 | Token address matches the stored address |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
The bench drives an event pulse and a clear of the same bit in one cycle. A design that lets the clear win would lose the event and read the bit back as 0.

It also sets mask bit 7 while `dma_busy` is high. A design that feeds bit 7 into the request would raise `irq`, and one that latches `dma_busy` would keep bit 7 set after the level drops.

Masked events must still show up in status. Writes to unmapped offsets must leave every register unchanged. Token addresses that differ from the stored address only in bit 7 must still match, which catches an 8-bit compare. Random mixed traffic checks that `irq` follows status and mask exactly one cycle later, which catches a request path that is combinational or two cycles late.

// File: rtl/usbdev_reg_pkg.sv
// Package: register offsets and event layout shared by the register bank.
// Assumes an 8-bit offset space on the host bus.
package usbdev_reg_pkg;
    localparam logic [7:0] OFS_IRQ_MASK = 8'h06;
    localparam logic [7:0] OFS_DEV_ADDR = 8'h07;
    localparam logic [7:0] OFS_IRQ_STAT = 8'h0D;
    // events beyond the per-endpoint ones: DMA done, start-of-frame, bus reset
    localparam int unsigned NON_EP_EVENTS = 3;
endpackage

// File: rtl/usbdev_evt_latch.sv
// Module: sticky event latches with write-1-to-clear.
// One flop per event. A pulse sets the bit, and a clear bit resets it.
// When both arrive in the same cycle, the set wins.
// Assumes event pulses are synchronous to clk.
module usbdev_evt_latch #(
    parameter int unsigned WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] stat_o
);
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        logic flag_q;
        // per-bit latch: the set takes priority over the clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q <= 1'b0;
            else if (evt_i[gi])
                flag_q <= 1'b1;
            else if (clr_i[gi])
                flag_q <= 1'b0;
        end
        assign stat_o[gi] = flag_q;
    end
endmodule

// File: rtl/usbdev_irq_drive.sv
// Module: registered interrupt request.
// Raises the request from pending bits whose mask bit is set.
// Assumes the mask and status vectors are bit-aligned.
module usbdev_irq_drive #(
    parameter int unsigned WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] mask_i,
    input  logic [WIDTH-1:0] stat_i,
    output logic             irq_o
);
    logic any_pending;

    // reduce the masked pending bits to a single request
    always_comb any_pending = |(mask_i & stat_i);

    // register the request so the output is glitch-free
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else
            irq_o <= any_pending;
    end
endmodule

// File: rtl/usbdev_addr_cmp.sv
// Module: token address comparator.
// Purely combinational equality check.
// Assumes the caller passes only the address bits that take part in the compare.
module usbdev_addr_cmp #(
    parameter int unsigned TOK_W = 7
) (
    input  logic [TOK_W-1:0] dev_addr_i,
    input  logic [TOK_W-1:0] tok_addr_i,
    output logic             hit_o
);
    // flag equality of the token address and the stored address
    always_comb hit_o = (dev_addr_i == tok_addr_i);
endmodule

// File: rtl/usbdev_irq_regs.sv
// Module: interrupt mask, status and device address register bank.
// Host-bus writes take effect at the clock edge. Reads are combinational.
// Assumes one write per strobe cycle and events as single-cycle pulses.
module usbdev_irq_regs
    import usbdev_reg_pkg::*;
#(
    parameter int unsigned NUM_EP = 4,
    parameter int unsigned TOK_W  = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              bus_addr,
    input  logic [NUM_EP+3:0]       bus_wdata,
    input  logic                    bus_wr,
    output logic [NUM_EP+3:0]       bus_rdata,
    input  logic [NUM_EP-1:0]       ev_ep_done,
    input  logic                    ev_dma_done,
    input  logic                    ev_sof,
    input  logic                    ev_bus_reset,
    input  logic                    dma_busy,
    input  logic [TOK_W-1:0]        tok_addr,
    output logic                    addr_hit,
    output logic                    irq
);
    localparam int unsigned EVT_W = NUM_EP + NON_EP_EVENTS;
    localparam int unsigned DW    = EVT_W + 1;

    logic             sel_mask, sel_addr, sel_stat;
    logic [EVT_W-1:0] ev_vec;
    logic [EVT_W-1:0] clr_vec;
    logic [EVT_W-1:0] stat_q;
    logic [DW-1:0]    en_q;
    logic [DW-1:0]    dev_addr_q;

    // decode the offset into register selects
    always_comb begin
        sel_mask = (bus_addr == OFS_IRQ_MASK);
        sel_addr = (bus_addr == OFS_DEV_ADDR);
        sel_stat = (bus_addr == OFS_IRQ_STAT);
    end

    // gather event pulses in status bit order, and form the clear vector
    always_comb begin
        ev_vec  = {ev_bus_reset, ev_sof, ev_dma_done, ev_ep_done};
        clr_vec = (bus_wr && sel_stat) ? bus_wdata[EVT_W-1:0] : '0;
    end

    // mask register: plain read/write storage
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (bus_wr && sel_mask)
            en_q <= bus_wdata;
    end

    // device address register: plain read/write storage
    always_ff @(posedge clk) begin
        if (!rst_n)
            dev_addr_q <= '0;
        else if (bus_wr && sel_addr)
            dev_addr_q <= bus_wdata;
    end

    usbdev_evt_latch #(.WIDTH(EVT_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (ev_vec),
        .clr_i  (clr_vec),
        .stat_o (stat_q)
    );

    usbdev_irq_drive #(.WIDTH(EVT_W)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .mask_i (en_q[EVT_W-1:0]),
        .stat_i (stat_q),
        .irq_o  (irq)
    );

    usbdev_addr_cmp #(.TOK_W(TOK_W)) u_cmp (
        .dev_addr_i (dev_addr_q[TOK_W-1:0]),
        .tok_addr_i (tok_addr),
        .hit_o      (addr_hit)
    );

    // read mux; the top status bit is the live DMA busy level
    always_comb begin
        bus_rdata = '0;
        if (sel_mask)
            bus_rdata = en_q;
        else if (sel_addr)
            bus_rdata = dev_addr_q;
        else if (sel_stat)
            bus_rdata = {dma_busy, stat_q};
    end
endmodule

// File: rtl/usbdev_irq_regs_chk.sv
// Module: assertion checker for usbdev_irq_regs, attached by bind.
// Observes bus ports and the latched status and mask state.
module usbdev_irq_regs_chk
    import usbdev_reg_pkg::*;
#(
    parameter int unsigned EVT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       bus_addr,
    input logic [EVT_W:0]   bus_wdata,
    input logic             bus_wr,
    input logic [EVT_W:0]   bus_rdata,
    input logic             dma_busy,
    input logic [EVT_W-1:0] ev_vec,
    input logic [EVT_W-1:0] stat_q,
    input logic [EVT_W:0]   en_q,
    input logic             irq
);
    p_evt_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vec != '0) |=> ((stat_q & $past(ev_vec)) == $past(ev_vec)));

    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == OFS_IRQ_STAT) |=> (($past(stat_q) & ~stat_q) == '0));

    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_IRQ_STAT && ev_vec == '0)
        |=> ((stat_q & $past(bus_wdata[EVT_W-1:0])) == '0));

    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_IRQ_STAT && (ev_vec & bus_wdata[EVT_W-1:0]) != '0)
        |=> ((stat_q & $past(ev_vec)) == $past(ev_vec)));

    p_dma_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_IRQ_STAT) |-> (bus_rdata[EVT_W] == dma_busy));

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_q[EVT_W-1:0] & stat_q) == '0) |=> !irq);

    p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_q[EVT_W-1:0] & stat_q) != '0) |=> irq);
endmodule

bind usbdev_irq_regs usbdev_irq_regs_chk #(.EVT_W(EVT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .dma_busy  (dma_busy),
    .ev_vec    (ev_vec),
    .stat_q    (stat_q),
    .en_q      (en_q),
    .irq       (irq)
);

// File: tb/usbdev_irq_regs_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases, then seeded random traffic, checked against a
// cycle model kept in bench variables.
module usbdev_irq_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] bus_addr, bus_wdata, bus_rdata;
    logic       bus_wr;
    logic [3:0] ev_ep_done;
    logic       ev_dma_done, ev_sof, ev_bus_reset, dma_busy;
    logic [6:0] tok_addr;
    logic       addr_hit, irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model state
    logic [7:0] m_en = '0, m_addr = '0;
    logic [6:0] m_stat = '0;
    logic       m_irq = 1'b0;
    logic [7:0] seen_rd;

    always #2 clk = ~clk;

    usbdev_irq_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rdata(bus_rdata), .ev_ep_done(ev_ep_done),
        .ev_dma_done(ev_dma_done), .ev_sof(ev_sof), .ev_bus_reset(ev_bus_reset),
        .dma_busy(dma_busy), .tok_addr(tok_addr), .addr_hit(addr_hit), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_rd(input logic [7:0] a, input logic dma);
        case (a)
            8'h06:   return m_en;
            8'h07:   return m_addr;
            8'h0D:   return {dma, m_stat};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rd_tag(input logic [7:0] a);
        case (a)
            8'h06:   return "R2";
            8'h07:   return "R3";
            8'h0D:   return "R5";
            default: return "R10";
        endcase
    endfunction

    // one bus cycle: drive, check the current state, then advance the model
    task automatic step(input logic [7:0] a, input logic [7:0] d, input logic w,
                        input logic [6:0] e, input logic dma, input logic [6:0] tok);
        logic [6:0] clr;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = w;
        {ev_bus_reset, ev_sof, ev_dma_done, ev_ep_done} = e;
        dma_busy = dma; tok_addr = tok;
        #1;
        seen_rd = bus_rdata;
        chk(rd_tag(a), bus_rdata, model_rd(a, dma));
        chk("R8", irq, m_irq);
        chk("R9", addr_hit, tok == m_addr[6:0]);
        @(posedge clk);
        m_irq  = |(m_stat & m_en[6:0]);
        clr    = (w && a == 8'h0D) ? d[6:0] : 7'h0;
        m_stat = (m_stat & ~clr) | e;
        if (w && a == 8'h06) m_en = d;
        if (w && a == 8'h07) m_addr = d;
    endtask

    task automatic rd(input logic [7:0] a, input logic dma);
        step(a, 8'h00, 1'b0, 7'h0, dma, 7'h00);
    endtask

    // watchdog: an expired run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0;
        ev_ep_done = '0; ev_dma_done = 1'b0; ev_sof = 1'b0; ev_bus_reset = 1'b0;
        dma_busy = 1'b0; tok_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        rd(8'h06, 1'b0); chk("R1", seen_rd, 8'h00);
        rd(8'h07, 1'b0); chk("R1", seen_rd, 8'h00);
        rd(8'h0D, 1'b0); chk("R1", seen_rd, 8'h00);
        chk("R1", irq, 1'b0);

        // R10: unmapped write changes nothing and reads 0
        step(8'h08, 8'hFF, 1'b1, 7'h0, 1'b0, 7'h00);
        step(8'h0C, 8'hFF, 1'b1, 7'h0, 1'b0, 7'h00);
        rd(8'h08, 1'b0); chk("R10", seen_rd, 8'h00);
        rd(8'h06, 1'b0); chk("R10", seen_rd, 8'h00);
        rd(8'h07, 1'b0); chk("R10", seen_rd, 8'h00);

        // R4: masked event still latches; no irq
        step(8'h00, 8'h00, 1'b0, 7'h08, 1'b0, 7'h00);
        rd(8'h0D, 1'b0); chk("R4", seen_rd, 8'h08);
        rd(8'h0D, 1'b0); chk("R4", irq, 1'b0);

        // R5: clear with mixed bits
        step(8'h00, 8'h00, 1'b0, 7'h41, 1'b0, 7'h00);
        step(8'h0D, 8'h09, 1'b1, 7'h0, 1'b0, 7'h00);
        rd(8'h0D, 1'b0); chk("R5", seen_rd, 8'h40);
        step(8'h0D, 8'hFF, 1'b1, 7'h0, 1'b0, 7'h00);

        // R6: event and clear of the same bit in one cycle
        step(8'h06, 8'h7F, 1'b1, 7'h0, 1'b0, 7'h00);
        step(8'h0D, 8'hFF, 1'b1, 7'h20, 1'b0, 7'h00);
        rd(8'h0D, 1'b0); chk("R6", seen_rd, 8'h20);
        rd(8'h0D, 1'b0); chk("R8", irq, 1'b1);
        step(8'h0D, 8'hFF, 1'b1, 7'h0, 1'b0, 7'h00);

        // R7: live busy bit, mask bit 7 set, no irq
        step(8'h06, 8'h80, 1'b1, 7'h0, 1'b1, 7'h00);
        rd(8'h0D, 1'b1); chk("R7", seen_rd, 8'h80);
        rd(8'h0D, 1'b1); chk("R7", irq, 1'b0);
        rd(8'h0D, 1'b0); chk("R7", seen_rd, 8'h00);

        // R3 / R9: bit 7 of the address is ignored in the compare
        step(8'h07, 8'hA5, 1'b1, 7'h0, 1'b0, 7'h00);
        rd(8'h07, 1'b0); chk("R3", seen_rd, 8'hA5);
        step(8'h00, 8'h00, 1'b0, 7'h0, 1'b0, 7'h25); chk("R9", addr_hit, 1'b1);
        step(8'h00, 8'h00, 1'b0, 7'h0, 1'b0, 7'h24); chk("R9", addr_hit, 1'b0);

        // random mixed traffic
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] a;
            logic [6:0] e, tok;
            int sel = $urandom_range(0, 3);
            a = (sel == 0) ? 8'h06 : (sel == 1) ? 8'h07 : (sel == 2) ? 8'h0D
                : 8'($urandom_range(0, 15));
            e = '0;
            for (int b = 0; b < 7; b++) if ($urandom_range(0, 9) == 0) e[b] = 1'b1;
            tok = ($urandom_range(0, 2) == 0) ? m_addr[6:0] : 7'($urandom);
            step(a, 8'($urandom), ($urandom_range(0, 2) == 0), e,
                 1'($urandom), tok);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule